// File: doc/BRIEF.md
# Three-Phase Current Sample Accumulator

The block sums ADC current samples for three motor phases over the interval between two host readouts. Each accepted sample strobe adds one 12-bit value to each of three running sums and increments a sample count that all three phases share. When a host transfer completes, the host side raises a clear request. On that cycle the block copies the sums and the count into snapshot registers for readout. It then restarts the live sums and the live count from zero. The host divides each sum by the count to get an average current per phase over the readout interval.

Samples arrive on a one-way valid stream with no ready signal and no back-pressure. The block takes a sample on every cycle in which `in_valid` is high. The clear request and the snapshot outputs are plain level signals. Lane 0 carries phase 1, lane 1 carries phase 2 and lane 2 carries phase 3. This mapping is fixed. The shared count saturates, which bounds the largest possible sum, so the sums never wrap.

Top module: `adc_current_accumulator`

## Requirements
- R1: A synchronous reset sets all three snapshot sums and the snapshot count to zero. It also empties the live accumulators.
- R2: On a clear request, `snap_count` takes the number of cycles since the previous clear (or reset) in which `in_valid` was high, up to the saturation limit of R5.
- R3: On a clear request, `snap_sum0`, `snap_sum1` and `snap_sum2` take the sums of the accepted samples of `in_smp0` (phase 1), `in_smp1` (phase 2) and `in_smp2` (phase 3) respectively. The sums are zero-extended to 24 bits.
- R4: A sample that is valid in the same cycle as a clear request is included in that snapshot and not in the next interval. The next interval starts from a count and sums of zero.
- R5: The live count is 8 bits wide and stops at 255. Valid samples that arrive while the count is 255 are discarded and leave the sums unchanged until the next clear.
- R6: The snapshot outputs change only on the clock edge that ends a clear-request cycle. Between clears they hold their values.
- R7: A clear request with no accepted sample since the previous clear produces a snapshot of zero count and zero sums.
- R8: Clear requests in two consecutive cycles produce a second snapshot that holds only the sample of the second clear cycle, if that sample is valid.
- R9: Sample values present while `in_valid` is low have no effect on any sum or on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; no back-pressure |
| in_smp0 | input | 12 | Phase 1 current sample |
| in_smp1 | input | 12 | Phase 2 current sample |
| in_smp2 | input | 12 | Phase 3 current sample |
| clr_req | input | 1 | Host transfer done: snapshot and restart |
| snap_sum0 | output | 24 | Phase 1 snapshot sum |
| snap_sum1 | output | 24 | Phase 2 snapshot sum |
| snap_sum2 | output | 24 | Phase 3 snapshot sum |
| snap_count | output | 8 | Snapshot sample count |

## Verification
Two events can fall in the same cycle: a sample being accepted and a clear request. The same holds for saturation and a clear request. The bench issues clears on cycles that carry a valid sample, on idle cycles, on back-to-back cycles, and right after driving the count past 255 with full-scale samples. The random phase also lets clears and strobes coincide freely. After each edge, a bench model checks that the coinciding sample lands in the closing snapshot and that the new interval starts at zero.

// File: rtl/adc_acc_pkg.sv
package adc_acc_pkg;
  parameter int NUM_PHASES   = 3;
  parameter int DEF_SMP_W    = 12;
  parameter int DEF_CNT_W    = 8;
  parameter int DEF_SUM_W    = 24;
endpackage

// File: rtl/adc_acc_count.sv
module adc_acc_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             clr,
  output logic             accept,
  output logic [CNT_W-1:0] snap_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] live_cnt;
  logic [CNT_W-1:0] cnt_inc;

  assign accept  = in_valid && (live_cnt != CNT_MAX);
  assign cnt_inc = live_cnt + CNT_W'(accept);

  always_ff @(posedge clk) begin
    if (rst) begin
      live_cnt <= '0;
      snap_cnt <= '0;
    end else if (clr) begin
      snap_cnt <= cnt_inc;
      live_cnt <= '0;
    end else begin
      live_cnt <= cnt_inc;
    end
  end

  // R5: a full count stays full until a clear
  a_r5_count_cap: assert property (@(posedge clk) disable iff (rst)
    (live_cnt == CNT_MAX && !clr) |=> live_cnt == CNT_MAX);
  // R4: live count restarts at zero after a clear
  a_r4_count_restart: assert property (@(posedge clk) disable iff (rst)
    clr |=> live_cnt == '0);
  // R9: idle cycles leave the live count alone
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !clr) |=> $stable(live_cnt));
  // R6: snapshot count holds between clears
  a_r6_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    !clr |=> $stable(snap_cnt));
endmodule

// File: rtl/adc_acc_lane.sv
module adc_acc_lane #(
  parameter int SMP_W = 12,
  parameter int SUM_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             clr,
  input  logic [SMP_W-1:0] smp,
  output logic [SUM_W-1:0] snap_sum
);
  localparam int PAD_W = SUM_W - SMP_W;

  logic [SUM_W-1:0] live_sum;
  logic [SUM_W-1:0] addend;
  logic [SUM_W-1:0] sum_inc;

  assign addend  = accept ? {{PAD_W{1'b0}}, smp} : '0;
  assign sum_inc = live_sum + addend;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_sum <= '0;
      snap_sum <= '0;
    end else if (clr) begin
      snap_sum <= sum_inc;
      live_sum <= '0;
    end else begin
      live_sum <= sum_inc;
    end
  end

  // R5: the bounded count keeps the sum from wrapping
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !clr |=> live_sum >= $past(live_sum));
  // R4: live sum restarts at zero after a clear
  a_r4_sum_restart: assert property (@(posedge clk) disable iff (rst)
    clr |=> live_sum == '0);
  // R6: snapshot sum holds between clears
  a_r6_sum_hold: assert property (@(posedge clk) disable iff (rst)
    !clr |=> $stable(snap_sum));
endmodule

// File: rtl/adc_current_accumulator.sv
module adc_current_accumulator
  import adc_acc_pkg::*;
#(
  parameter int SMP_W = DEF_SMP_W,
  parameter int CNT_W = DEF_CNT_W,
  parameter int SUM_W = DEF_SUM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SMP_W-1:0] in_smp0,
  input  logic [SMP_W-1:0] in_smp1,
  input  logic [SMP_W-1:0] in_smp2,
  input  logic             clr_req,
  output logic [SUM_W-1:0] snap_sum0,
  output logic [SUM_W-1:0] snap_sum1,
  output logic [SUM_W-1:0] snap_sum2,
  output logic [CNT_W-1:0] snap_count
);
  logic                          accept;
  logic [NUM_PHASES-1:0][SMP_W-1:0] smp_vec;
  logic [NUM_PHASES-1:0][SUM_W-1:0] snap_vec;

  // lane i carries phase i+1
  assign smp_vec[0] = in_smp0;
  assign smp_vec[1] = in_smp1;
  assign smp_vec[2] = in_smp2;

  adc_acc_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .clr      (clr_req),
    .accept   (accept),
    .snap_cnt (snap_count)
  );

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_lane
    adc_acc_lane #(.SMP_W(SMP_W), .SUM_W(SUM_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .accept   (accept),
      .clr      (clr_req),
      .smp      (smp_vec[g]),
      .snap_sum (snap_vec[g])
    );
  end

  assign snap_sum0 = snap_vec[0];
  assign snap_sum1 = snap_vec[1];
  assign snap_sum2 = snap_vec[2];

  // R5: width budget, checked once at start
  initial a_r5_width_budget: assert (SUM_W >= SMP_W + CNT_W);

  // R7: a clear right after a clear with no valid strobe yields an empty snapshot
  a_r7_empty_clear: assert property (@(posedge clk) disable iff (rst)
    ($past(clr_req) && clr_req && !in_valid) |=> snap_count == '0);
endmodule

// File: tb/adc_current_accumulator_bench.sv
module adc_current_accumulator_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [11:0] in_smp0 = '0, in_smp1 = '0, in_smp2 = '0;
  logic        clr_req = 1'b0;
  logic [23:0] snap_sum0, snap_sum1, snap_sum2;
  logic [7:0]  snap_count;

  int checks = 0;
  int errors = 0;

  int m_cnt;
  int m_sum [3];
  int e_cnt;
  int e_sum [3];

  always #2.5 clk = ~clk;

  adc_current_accumulator u_adc_current_accumulator (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_smp0(in_smp0), .in_smp1(in_smp1), .in_smp2(in_smp2),
    .clr_req(clr_req),
    .snap_sum0(snap_sum0), .snap_sum1(snap_sum1), .snap_sum2(snap_sum2),
    .snap_count(snap_count)
  );

  function automatic bit accepts(input bit v, input int cnt);
    return v && (cnt < 255);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, snap_count, e_cnt);
    chk(tag, snap_sum0, e_sum[0]);
    chk(tag, snap_sum1, e_sum[1]);
    chk(tag, snap_sum2, e_sum[2]);
  endtask

  // called at a negedge; leaves inputs idle at the following negedge
  task automatic step(input bit v, input int a, input int b, input int c,
                      input bit clr, input string tag);
    int s [3];
    bit acc;
    s[0] = a; s[1] = b; s[2] = c;
    in_valid = v; in_smp0 = 12'(a); in_smp1 = 12'(b); in_smp2 = 12'(c);
    clr_req = clr;
    @(posedge clk);
    acc = accepts(v, m_cnt);
    for (int i = 0; i < 3; i++) if (acc) m_sum[i] += s[i];
    if (acc) m_cnt++;
    if (clr) begin
      e_cnt = m_cnt;
      for (int i = 0; i < 3; i++) begin e_sum[i] = m_sum[i]; m_sum[i] = 0; end
      m_cnt = 0;
    end
    @(negedge clk);
    check_all(clr ? tag : "R6");
    in_valid = 1'b0; clr_req = 1'b0;
    in_smp0 = 12'(a ^ 12'hA5A); in_smp1 = 12'(b ^ 12'h5A5); in_smp2 = 12'hFFF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_cnt = 0; e_cnt = 0;
    for (int i = 0; i < 3; i++) begin m_sum[i] = 0; e_sum[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1");

    // R2 R3: distinct per-phase values, then clear on an idle cycle
    step(1, 100, 200, 300, 0, "R3");
    step(1, 4095, 1, 2048, 0, "R3");
    step(0, 7, 7, 7, 0, "R9");
    step(1, 10, 20, 30, 0, "R3");
    step(0, 999, 999, 999, 1, "R2");
    // R4: sample in the clear cycle joins the closing snapshot
    step(1, 5, 6, 7, 0, "R4");
    step(1, 11, 22, 33, 1, "R4");
    // R8: back-to-back clears, second carries one sample
    step(1, 1, 2, 3, 1, "R8");
    // R7: empty interval
    step(0, 50, 50, 50, 1, "R7");
    // R9: invalid samples only, then clear
    for (int k = 0; k < 5; k++) step(0, 4095, 4095, 4095, 0, "R9");
    step(0, 0, 0, 0, 1, "R9");
    // R5: saturate with full-scale samples, clear on a valid cycle
    for (int k = 0; k < 300; k++) step(1, 4095, 4095, 4095, 0, "R5");
    step(1, 4095, 4095, 4095, 1, "R5");
    chk("R5", snap_count, 255);
    chk("R5", snap_sum0, 255 * 4095);
    // R5: exactly 254 then one valid in the clear cycle reaches 255
    for (int k = 0; k < 254; k++) step(1, 1, 2, 3, 0, "R5");
    step(1, 1, 2, 3, 1, "R5");
    chk("R5", snap_count, 255);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      bit v, c;
      v = ($urandom_range(0, 9) < 7);
      c = ($urandom_range(0, 39) == 0);
      step(v, $urandom_range(0, 4095), $urandom_range(0, 4095),
           $urandom_range(0, 4095), c, "R2");
    end
    step(1, 3, 3, 3, 1, "R4");

    // R1: reset mid-interval clears snapshots and live state
    step(1, 9, 9, 9, 0, "R3");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_cnt = 0; e_cnt = 0;
    for (int i = 0; i < 3; i++) begin m_sum[i] = 0; e_sum[i] = 0; end
    check_all("R1");
    step(0, 0, 0, 0, 1, "R1");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule